// File: doc/BRIEF.md
# Inter-core set/clear mailbox bank

The block holds sixteen 32-bit mailboxes that processor cores use to signal one another. There are four mailboxes for each of four cores. Any bus master can raise bits in any mailbox through a write-set window: the write data is ORed into the mailbox. The receiving core drops bits through a separate window. In that window a write of 1 clears the bit, and a read returns the current contents. This clear window is the only place where a mailbox can be read.

Each mailbox drives a pending flag. The flag is high whenever the mailbox holds any set bit, and it feeds a downstream interrupt router. The flags come out as one 16-bit vector with one register stage. Every access is a single-cycle 32-bit request on a simple register bus. Read data appears one cycle after the request.

Top module: `mbox_bank`

## Requirements
- R1: After reset every mailbox holds zero, `pend_o` is all zero, and `rdata_o` is zero.
- R2: A full-word write to byte offset 0x80 + 4*i ORs `wdata_i` into mailbox i and leaves bits that are already set unchanged. Mailbox j of core c has index i = c*4 + j.
- R3: A full-word write to byte offset 0xC0 + 4*i clears each bit of mailbox i for which `wdata_i` is 1 and keeps every other bit.
- R4: A read at 0xC0 + 4*i puts the contents of mailbox i on `rdata_o` in the cycle after the request. A read in the set window 0x80–0xBF returns 0.
- R5: `pend_o[i]` is 1 exactly when mailbox i is nonzero, delayed by one cycle after the storage update. A write at clock edge k therefore shows on `pend_o` after edge k+1.
- R6: An access whose byte enables `be_i` are not all ones (4'hF), or whose address has bits [1:0] nonzero, changes no mailbox and reads 0.
- R7: Offsets below 0x80 change no mailbox and read 0.
- R8: A write-set followed in the very next cycle by a write-clear of the same bits leaves the mailbox empty. Each write updates storage on the clock edge of its own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| be_i | input | 4 | Byte enables; only 4'hF is accepted |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request, 0 otherwise |
| pend_o | output | 16 | Registered per-mailbox nonzero flags |

## Verification
The cell assertions take for granted that the decoder never asserts set and clear for the same mailbox in one cycle. This holds because the bus carries only one access per cycle. The bench keeps to that rule: it drives every access on the falling edge, holds it for exactly one cycle, and never overlaps two requests. Rejected accesses (partial enables, misaligned or low offsets) are driven only while the bench's model already holds known contents. The bench then reads those contents back through the clear window and checks `pend_o`, which shows whether the rejected access changed anything.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_BYTES = 4;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_RD   = 2'd3
  } acc_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int NUM_BOX = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  localparam int IDX_W  = $clog2(NUM_BOX),
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  output acc_e              kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int WIN      = NUM_BOX * WORD_BYTES;
  localparam int SET_BASE = 2 * WIN;
  localparam int CLR_BASE = 3 * WIN;

  logic ok, in_set, in_clr;

  assign ok     = req_i && (be_i == '1) && (addr_i[1:0] == 2'b00);
  assign in_set = (addr_i >= ADDR_W'(SET_BASE)) && (addr_i < ADDR_W'(CLR_BASE));
  assign in_clr = (addr_i >= ADDR_W'(CLR_BASE));
  // windows are WIN-aligned, so the low offset bits give the index directly
  assign idx_o  = addr_i[IDX_W+1:2];

  always_comb begin
    kind_o = ACC_NONE;
    if (ok) begin
      if (we_i && in_set)       kind_o = ACC_SET;
      else if (we_i && in_clr)  kind_o = ACC_CLR;
      else if (!we_i && in_clr) kind_o = ACC_RD;
    end
  end
endmodule

// File: rtl/mbox_cell.sv
module mbox_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] mb_o,
  output logic              nz_o
);
  logic [DATA_W-1:0] mb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mb_q <= '0;
    else if (set_i) mb_q <= mb_q | data_i;
    else if (clr_i) mb_q <= mb_q & ~data_i;
  end

  assign mb_o = mb_q;
  assign nz_o = |mb_q;

  // R2
  set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((mb_o & $past(data_i)) == $past(data_i)));

  // R3
  clr_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((mb_o & $past(data_i)) == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(mb_o));
endmodule

// File: rtl/mbox_pend.sv
module mbox_pend #(
  parameter int NUM_BOX = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BOX-1:0] nz_i,
  output logic [NUM_BOX-1:0] pend_o
);
  logic [NUM_BOX-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= nz_i;
  end

  assign pend_o = pend_q;

  // R5
  pend_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_o == $past(nz_i)));
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int NUM_CORES    = 4,
  parameter int BOX_PER_CORE = 4,
  parameter int DATA_W       = 32,
  localparam int NUM_BOX     = NUM_CORES * BOX_PER_CORE,
  localparam int IDX_W       = $clog2(NUM_BOX),
  localparam int ADDR_W      = $clog2(NUM_BOX * WORD_BYTES * 4),
  localparam int BE_W        = DATA_W / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BE_W-1:0]    be_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_BOX-1:0] pend_o
);
  acc_e              kind;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] mb   [NUM_BOX];
  logic [NUM_BOX-1:0] nz;
  logic [DATA_W-1:0] rdata_q;

  mbox_decode #(
    .NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .be_i(be_i),
    .kind_o(kind), .idx_o(idx)
  );

  for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
    logic hit;
    assign hit = (idx == IDX_W'(i));
    mbox_cell #(.DATA_W(DATA_W)) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(hit && (kind == ACC_SET)),
      .clr_i(hit && (kind == ACC_CLR)),
      .data_i(wdata_i),
      .mb_o(mb[i]), .nz_o(nz[i])
    );
  end

  mbox_pend #(.NUM_BOX(NUM_BOX)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .nz_i(nz), .pend_o(pend_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (kind == ACC_RD)  rdata_q <= mb[idx];
    else                      rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  // R4
  rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind != ACC_RD) |=> (rdata_o == '0));

  // R4
  rd_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == ACC_RD) |=> (rdata_o == $past(mb[idx])));

  // R7
  low_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i < ADDR_W'(NUM_BOX * WORD_BYTES * 2)) |-> (kind == ACC_NONE));
endmodule

// File: tb/mbox_bank_test.sv
module mbox_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pend;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] model [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_bank uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .pend_o(pend)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 0; we = 0; be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a; be = 4'hF;
    @(negedge clk);
    d = rdata;
    req = 0; be = '0;
  endtask

  function automatic logic [31:0] exp_pend();
    logic [31:0] p = '0;
    for (int i = 0; i < NB; i++) p[i] = |model[i];
    return p;
  endfunction

  task automatic chk_box(input string rq, input int i);
    logic [31:0] d;
    rd(8'hC0 + 8'(4*i), d);
    chk(rq, d, model[i]);
    chk({rq, " pend"}, {16'h0, pend}, exp_pend());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NB; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 pend", {16'h0, pend}, 32'h0);
    rst_ni = 1;
    for (int i = 0; i < NB; i++) chk_box("R1", i);

    // R2 R3 R5 sweep per core/mailbox
    for (int c = 0; c < 4; c++) begin
      for (int j = 0; j < 4; j++) begin
        int i = c*4 + j;
        logic [31:0] p1 = (32'h1 << i) | 32'h8000_0000;
        logic [31:0] p2 = 32'h00F0_0000 ^ 32'(i);
        wr(8'h80 + 8'(4*i), p1, 4'hF); model[i] |= p1;
        @(negedge clk);
        chk("R5 pend after set", {16'h0, pend}, exp_pend());
        chk_box("R2 set", i);
        wr(8'h80 + 8'(4*i), p2, 4'hF); model[i] |= p2;
        chk_box("R2 or-in", i);
        rd(8'h80 + 8'(4*i), d);
        chk("R4 set window read", d, 32'h0);
        wr(8'hC0 + 8'(4*i), p1, 4'hF); model[i] &= ~p1;
        chk_box("R3 partial clear", i);
      end
    end
    // R6 partial enables and misaligned
    wr(8'h84, 32'hFFFF_FFFF, 4'h3);
    chk_box("R6 partial be", 1);
    wr(8'hC6, 32'hFFFF_FFFF, 4'hF);
    chk_box("R6 misaligned", 1);
    // R7 low offsets
    wr(8'h10, 32'hFFFF_FFFF, 4'hF);
    wr(8'h7C, 32'hFFFF_FFFF, 4'hF);
    for (int i = 0; i < NB; i++) chk_box("R7 low write", i);
    rd(8'h10, d);
    chk("R7 low read", d, 32'h0);
    // R3 full clear, all pend low
    for (int i = 0; i < NB; i++) begin
      wr(8'hC0 + 8'(4*i), 32'hFFFF_FFFF, 4'hF); model[i] = '0;
    end
    @(negedge clk);
    chk("R3 R5 all clear pend", {16'h0, pend}, 32'h0);
    // R8 back-to-back set then clear
    @(negedge clk);
    req = 1; we = 1; be = 4'hF; addr = 8'h94; wdata = 32'h0F0F_1234;
    @(negedge clk);
    addr = 8'hD4;
    @(negedge clk);
    req = 0; we = 0; be = '0;
    chk_box("R8 b2b", 5);
    @(negedge clk);
    chk("R8 pend", {16'h0, pend}, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule